// File: doc/BRIEF.md
# Linear chirp frequency generator

This block produces the frequency tuning word and the running phase for a direct digital synthesizer. In single-tone mode the tuning word is simply the programmed start word. In chirp mode the tuning word begins at the start word. A signed delta word is then added to it once per programmable ramp interval, which sweeps the frequency up or down in a straight line. A phase accumulator adds the tuning word every clock. Its value is the block's output and feeds a sine lookup placed downstream.

No end frequency can be programmed, and a chirp runs until something outside the block stops it. Three controls can do this. The hold input freezes the sweep and keeps the present frequency. A delta of zero stops the sweep at the present frequency. The clear-phase input forces the phase to zero and cuts the output at once. The tuning word never leaves the range from zero to the Nyquist value (half of 2^48). A sweep that reaches either end saturates there.

Top module: `chirp_gen`

## Requirements
- R1: While rst_ni is low, freq_word_o and phase_o are both 0.
- R2: When mode_i is any value other than 3'b011 (for example the default 3'b000), freq_word_o equals start_word_i one clock later and delta_word_i has no effect.
- R3: When mode_i is 3'b011 (chirp), on entry to chirp mode or after load_i, freq_word_o takes the start word and the ramp counter reloads from ramp_rate_i = N. The frequency then changes by delta_word_i every N+1 clocks.
- R4: On each clock without a clear, phase_o advances by the freq_word_o value it held before that edge, modulo 2^48.
- R5: A negative two's-complement delta_word_i lowers the frequency, and the result saturates at 0.
- R6: A positive step that would pass the Nyquist value 2^47 saturates at 2^47, so freq_word_o never exceeds 2^47.
- R7: While hold_i is high, freq_word_o and the ramp counter stay frozen, load_i and mode changes are ignored, and phase_o keeps advancing by the held word.
- R8: In chirp mode, a delta_word_i of zero keeps freq_word_o constant.
- R9: When clr_phase_i is high, phase_o is 0 after the next clock edge. The clear takes priority over the phase step.
- R10: A start_word_i above 2^47 is clamped to 2^47 when it is taken into the frequency accumulator.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 3 | Operating mode; 3'b011 chirp, others single tone |
| start_word_i | input | 48 | Start / single-tone tuning word |
| delta_word_i | input | 48 | Signed frequency step per ramp interval |
| ramp_rate_i | input | 20 | Ramp interval N; one step every N+1 clocks |
| load_i | input | 1 | Restart the chirp from the start word |
| hold_i | input | 1 | Freeze the frequency accumulator and ramp counter |
| clr_phase_i | input | 1 | Force the phase accumulator to zero |
| freq_word_o | output | 48 | Current tuning word |
| phase_o | output | 48 | Phase accumulator value |

## Verification
The bench aims at the two saturation edges. It drives sweeps with large positive steps into 2^47 and large negative steps into zero. A design that wraps at either edge would jump the frequency to the far end of the band. It checks the N+1 step spacing with ramp rates 0 and small values, because an off-by-one counter shifts every step by one clock and the phase drifts after that. Hold is combined with load and with mode changes to confirm that the freeze wins. Clear is applied on top of a sweep, where a design that let the phase step win would leave a non-zero phase behind.

// File: rtl/chirp_pkg.sv
package chirp_pkg;
  localparam int unsigned MODE_W = 3;
  localparam logic [MODE_W-1:0] MODE_TONE  = 3'b000;
  localparam logic [MODE_W-1:0] MODE_CHIRP = 3'b011;
endpackage

// File: rtl/chirp_ramp_timer.sv
module chirp_ramp_timer #(
  parameter int unsigned RATE_W = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hold_i,
  input  logic              restart_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              tick_o
);
  logic [RATE_W-1:0] cnt_q;
  logic              at_zero;

  assign at_zero = (cnt_q == '0);
  assign tick_o  = at_zero && !hold_i && !restart_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (hold_i)         cnt_q <= cnt_q;
    else if (restart_i)      cnt_q <= rate_i;
    else if (at_zero)        cnt_q <= rate_i;
    else                     cnt_q <= cnt_q - 1'b1;
  end

  // R7: counter frozen under hold
  a_r7_cnt_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> $stable(cnt_q));
endmodule

// File: rtl/chirp_freq_acc.sv
module chirp_freq_acc #(
  parameter int unsigned FREQ_W = 48
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hold_i,
  input  logic              restart_i,
  input  logic              tick_i,
  input  logic [FREQ_W-1:0] start_i,
  input  logic [FREQ_W-1:0] delta_i,
  output logic [FREQ_W-1:0] freq_o
);
  localparam logic [FREQ_W-1:0] NYQ = {1'b1, {(FREQ_W-1){1'b0}}};

  logic [FREQ_W-1:0]        freq_q, start_clamped, stepped;
  logic signed [FREQ_W+1:0] sum;

  assign start_clamped = (start_i > NYQ) ? NYQ : start_i;
  assign sum = $signed({2'b00, freq_q}) + $signed({{2{delta_i[FREQ_W-1]}}, delta_i});

  always_comb begin
    if (sum < 0)                           stepped = '0;
    else if (sum > $signed({2'b00, NYQ}))  stepped = NYQ;
    else                                   stepped = sum[FREQ_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         freq_q <= '0;
    else if (hold_i)     freq_q <= freq_q;
    else if (restart_i)  freq_q <= start_clamped;
    else if (tick_i)     freq_q <= stepped;
  end

  assign freq_o = freq_q;

  // R6: never above Nyquist
  a_r6_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    freq_q <= NYQ);
  // R7: frequency frozen under hold
  a_r7_freq_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> $stable(freq_q));
  // R5: negative delta never raises frequency
  a_r5_down_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_i && !restart_i && delta_i[FREQ_W-1]) |=> (freq_q <= $past(freq_q)));
  // R8: zero delta keeps frequency
  a_r8_zero_delta: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_i && !restart_i && delta_i == '0) |=> $stable(freq_q));
endmodule

// File: rtl/chirp_phase_acc.sv
module chirp_phase_acc #(
  parameter int unsigned PHASE_W = 48
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic [PHASE_W-1:0] tune_i,
  output logic [PHASE_W-1:0] phase_o
);
  logic [PHASE_W-1:0] phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     phase_q <= '0;
    else if (clr_i)  phase_q <= '0;
    else             phase_q <= phase_q + tune_i;
  end

  assign phase_o = phase_q;

  // R9: clear wins over step
  a_r9_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (phase_q == '0));
endmodule

// File: rtl/chirp_gen.sv
module chirp_gen
  import chirp_pkg::*;
#(
  parameter int unsigned FREQ_W  = 48,
  parameter int unsigned PHASE_W = 48,
  parameter int unsigned RATE_W  = 20
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [MODE_W-1:0]  mode_i,
  input  logic [FREQ_W-1:0]  start_word_i,
  input  logic [FREQ_W-1:0]  delta_word_i,
  input  logic [RATE_W-1:0]  ramp_rate_i,
  input  logic               load_i,
  input  logic               hold_i,
  input  logic               clr_phase_i,
  output logic [FREQ_W-1:0]  freq_word_o,
  output logic [PHASE_W-1:0] phase_o
);
  logic               restart, tick;
  logic [FREQ_W-1:0]  freq;
  logic [PHASE_W-1:0] tune;

  // single tone keeps the accumulator loaded with the start word
  assign restart = load_i || (mode_i != MODE_CHIRP);

  chirp_ramp_timer #(.RATE_W(RATE_W)) u_timer (
    .clk_i, .rst_ni, .hold_i, .restart_i(restart), .rate_i(ramp_rate_i), .tick_o(tick)
  );

  chirp_freq_acc #(.FREQ_W(FREQ_W)) u_freq (
    .clk_i, .rst_ni, .hold_i, .restart_i(restart), .tick_i(tick),
    .start_i(start_word_i), .delta_i(delta_word_i), .freq_o(freq)
  );

  generate
    if (PHASE_W <= FREQ_W) begin : g_tune_top
      assign tune = freq[FREQ_W-1 -: PHASE_W];
    end else begin : g_tune_ext
      assign tune = {{(PHASE_W-FREQ_W){1'b0}}, freq};
    end
  endgenerate

  chirp_phase_acc #(.PHASE_W(PHASE_W)) u_phase (
    .clk_i, .rst_ni, .clr_i(clr_phase_i), .tune_i(tune), .phase_o(phase_o)
  );

  assign freq_word_o = freq;
endmodule

// File: tb/chirp_gen_bench.sv
module chirp_gen_bench;
  localparam logic [47:0] NYQ = 48'h8000_0000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  mode = 3'b000;
  logic [47:0] start_w = '0, delta_w = '0;
  logic [19:0] rate = '0;
  logic        load = 1'b0, hold = 1'b0, clr = 1'b0;
  logic [47:0] freq_o, phase_o;

  int checks = 0, failures = 0;
  bit done = 0;
  string tag = "R1";

  logic [47:0] m_freq = '0, m_phase = '0;
  logic [19:0] m_cnt = '0;

  always #10 clk = ~clk;

  chirp_gen u_chirp_gen (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .start_word_i(start_w),
    .delta_word_i(delta_w), .ramp_rate_i(rate), .load_i(load), .hold_i(hold),
    .clr_phase_i(clr), .freq_word_o(freq_o), .phase_o(phase_o)
  );

  function automatic logic [47:0] clampf(logic [47:0] s);
    return (s > NYQ) ? NYQ : s;
  endfunction

  function automatic logic [47:0] satadd(logic [47:0] f, logic [47:0] d);
    logic signed [49:0] s;
    s = $signed({2'b00, f}) + $signed({{2{d[47]}}, d});
    if (s < 0) return '0;
    if (s > $signed({2'b00, NYQ})) return NYQ;
    return s[47:0];
  endfunction

  task automatic compare();
    checks++;
    if (freq_o !== m_freq) begin
      failures++;
      $display("FAIL %s freq act=%h exp=%h", tag, freq_o, m_freq);
    end
    checks++;
    if (phase_o !== m_phase) begin
      failures++;
      $display("FAIL %s phase act=%h exp=%h", tag, phase_o, m_phase);
    end
  endtask

  // advance one edge, update model from inputs present at that edge, compare
  task automatic step();
    logic rs;
    @(posedge clk); #1;
    rs = load || (mode != 3'b011);
    m_phase = clr ? '0 : m_phase + m_freq;
    if (!hold) begin
      if (rs) begin m_freq = clampf(start_w); m_cnt = rate; end
      else if (m_cnt == 0) begin m_cnt = rate; m_freq = satadd(m_freq, delta_w); end
      else m_cnt = m_cnt - 1'b1;
    end
    compare();
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  function automatic logic [47:0] rnd48();
    return {$urandom(), $urandom()};
  endfunction

  initial begin
    int seed0;
    seed0 = $urandom(32'd20240611);
    // R1: reset state
    tag = "R1";
    start_w = 48'h1234; mode = 3'b000;
    repeat (3) @(posedge clk);
    @(negedge clk); compare();
    @(negedge clk); rst_n = 1'b1;

    // R2: single tone ignores delta, in two modes
    tag = "R2";
    start_w = 48'h0000_1234_5678; delta_w = 48'h0000_0000_0100; rate = 0;
    run(10);
    mode = 3'b001; delta_w = 48'hFFFF_FFFF_0000; run(10);

    // R3: chirp, N=3, positive delta
    tag = "R3";
    mode = 3'b011; rate = 20'd3; delta_w = 48'h0000_0000_1000; run(30);
    // R4: phase wrap with large word
    tag = "R4";
    mode = 3'b000; start_w = NYQ - 48'd5; run(12);

    // R6: saturate at Nyquist
    tag = "R6";
    mode = 3'b011; rate = 0; load = 1; start_w = NYQ - 48'd300;
    delta_w = 48'd100; step(); load = 0; run(10);
    delta_w = 48'h7FFF_FFFF_FFFF; run(3);

    // R5: down-chirp saturates at zero
    tag = "R5";
    load = 1; start_w = 48'd250; delta_w = -48'sd100; rate = 1; step(); load = 0;
    run(12);
    delta_w = 48'h8000_0000_0000; run(3);

    // R8: zero delta
    tag = "R8";
    load = 1; start_w = 48'h0000_0F00_0000; delta_w = '0; rate = 0; step(); load = 0;
    run(10);

    // R7: hold freezes freq; load and mode change ignored
    tag = "R7";
    delta_w = 48'h10; rate = 2; run(5);
    hold = 1; run(4); load = 1; start_w = 48'h55; run(2);
    load = 0; mode = 3'b000; run(3); mode = 3'b011; hold = 0; run(8);

    // R9: clear on top of sweep
    tag = "R9";
    clr = 1; step(); clr = 0; run(3);
    clr = 1; run(3); clr = 0; run(2);

    // R10: start word clamp
    tag = "R10";
    mode = 3'b000; start_w = 48'hFFFF_0000_0001; run(4);
    mode = 3'b011; delta_w = 48'd1; rate = 0; run(4);

    // R3: constrained random mix
    tag = "R3";
    for (int seg = 0; seg < 60; seg++) begin
      mode    = ($urandom_range(0, 3) != 0) ? 3'b011 : 3'($urandom_range(0, 7));
      start_w = ($urandom_range(0, 7) == 0) ? rnd48() : {1'b0, rnd48()} >> 1;
      delta_w = 48'($signed(rnd48()) >>> $urandom_range(8, 47));
      rate    = 20'($urandom_range(0, 6));
      load    = 1'b1;
      step(); load = 0;
      for (int c = 0; c < 40; c++) begin
        hold = ($urandom_range(0, 9) == 0);
        clr  = ($urandom_range(0, 19) == 0);
        load = ($urandom_range(0, 29) == 0);
        step();
      end
      hold = 0; clr = 0; load = 0;
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule